// File: doc/BRIEF.md
# SPI Pad Control with Multi-Master Fault Detection

This block sits between an SPI shift engine and the four serial pads. A four-bit control word chooses whether the port is on, whether it acts as master or slave, whether the select pin is watched for a competing master, and whether the data pads use open-drain emulation. From the control word, the outgoing serial bit and the select pin, it computes the output value and output enable of the MOSI and MISO pads. It also routes the correct incoming pad to the engine's receive input.

Open-drain emulation releases the active data pad whenever a one is sent, so an external pull-up supplies the high level and two drivers cannot fight. While the port is an enabled master with select protection on, a low level on the active-low select input means another device has claimed the bus. The block then latches a sticky fault, releases both data pads, and holds a stop request to the shift engine until software clears the fault by writing one to the status address.

Top module: `spi_pad_ctrl`

## Requirements
- R1: After reset, the control readback is 0, both pad enables are low, and the fault flag and stop request are low.
- R2: A write to address 0 sets the control word with enable at bit 0, master select at bit 1, select protection at bit 2 and open-drain at bit 3. All four bits read back on `ctl_rdata` in the same positions on the clock edge that takes the write.
- R3: In master mode without open-drain, MOSI is enabled and carries the outgoing bit, and MISO is never enabled; the two pads are never enabled together.
- R4: In master mode with open-drain, MOSI is released when the outgoing bit is 1 and driven to 0 when the outgoing bit is 0.
- R5: In slave mode without open-drain, MISO is enabled and carries the outgoing bit only while the select input is low, and MOSI is never enabled.
- R6: In slave mode with open-drain, MISO is enabled (driving 0) only when the select input is low and the outgoing bit is 0.
- R7: With the enable bit clear, neither pad is enabled and no fault is raised, whatever the select input does.
- R8: A write that changes the master select bit has no effect while the enable bit is currently set. The same write is accepted when the port is disabled.
- R9: With enable, master and select protection all set, a select input that goes low and stays low sets the fault flag on the third rising clock edge after the fall, counting the two synchronizer stages. Without protection, or in slave mode, no fault is raised.
- R10: The fault is sticky. While it is set, both pad enables are low and `eng_stop` is high. Writing 1 to bit 0 at address 1 clears it, and writing 0 there leaves it set.
- R11: The engine's receive input follows the MISO pad in master mode and the MOSI pad in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status (write 1 to bit 0 clears fault) |
| reg_wdata | input | 4 | Write data |
| ctl_rdata | output | 4 | Current control word |
| eng_tx | input | 1 | Outgoing serial bit from the shift engine |
| eng_rx | output | 1 | Incoming serial bit to the shift engine |
| eng_stop | output | 1 | Stop request to the shift engine while faulted |
| mode_fault | output | 1 | Sticky multi-master fault flag |
| pad_ss_n_i | input | 1 | Slave-select pad input, active low |
| pad_mosi_i | input | 1 | MOSI pad input value |
| pad_mosi_o | output | 1 | MOSI pad output value |
| pad_mosi_oe | output | 1 | MOSI pad output enable |
| pad_miso_i | input | 1 | MISO pad input value |
| pad_miso_o | output | 1 | MISO pad output value |
| pad_miso_oe | output | 1 | MISO pad output enable |

## Verification
The bench samples the fault flag exactly two and three edges after the select pin falls. A design that drops a synchronizer stage, or adds one, shows up early or late. It sends both bit values under each mode and open-drain setting, so a design that inverts the release polarity or enables the wrong pad is caught. It tries a role change while enabled and one after disabling, which separates a missing lock from a lock that never opens. It writes zero to the status address and checks that the fault is still set, then checks that a protected slave and an unprotected master stay fault-free with select held low.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;

    localparam int unsigned CTL_BITS = 4;
    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_MSTR = 1;
    localparam int unsigned CTL_PSSE = 2;
    localparam int unsigned CTL_ODM  = 3;

    // Packed LSB-last: en lands on bit 0, odm on bit 3.
    typedef struct packed {
        logic odm;
        logic prot;
        logic mstr;
        logic en;
    } spi_ctl_t;

    typedef enum logic {
        ADDR_CTL  = 1'b0,
        ADDR_STAT = 1'b1
    } spi_addr_e;

endpackage

// File: rtl/spi_pad_cfg.sv
module spi_pad_cfg
    import spi_pad_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [CTL_BITS-1:0] wdata_i,
    output spi_ctl_t            ctl_o
);

    typedef struct packed {
        spi_ctl_t ctl;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d.ctl.en   = wdata_i[CTL_EN];
            state_d.ctl.prot = wdata_i[CTL_PSSE];
            state_d.ctl.odm  = wdata_i[CTL_ODM];
            // Role may only change while the port is currently off.
            if (!state_q.ctl.en) begin
                state_d.ctl.mstr = wdata_i[CTL_MSTR];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl_o = state_q.ctl;

endmodule

// File: rtl/spi_pad_sync.sv
module spi_pad_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.pipe[LAST];

endmodule

// File: rtl/spi_pad_fault.sv
module spi_pad_fault
    import spi_pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  spi_ctl_t ctl_i,
    input  logic     ss_n_sync_i,
    input  logic     clr_i,
    output logic     fault_o
);

    typedef struct packed {
        logic fault;
    } flt_state_t;

    flt_state_t state_d, state_q;
    logic       trip;

    always_comb begin
        trip    = ctl_i.en && ctl_i.mstr && ctl_i.prot && !ss_n_sync_i;
        state_d = state_q;
        if (clr_i) begin
            state_d.fault = 1'b0;
        end
        // A live fault condition beats a simultaneous clear.
        if (trip) begin
            state_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fault_o = state_q.fault;

endmodule

// File: rtl/spi_pad_drive.sv
module spi_pad_drive
    import spi_pad_pkg::*;
(
    input  spi_ctl_t ctl_i,
    input  logic     fault_i,
    input  logic     tx_i,
    input  logic     ss_n_i,
    input  logic     mosi_i,
    input  logic     miso_i,
    output logic     mosi_o,
    output logic     mosi_oe_o,
    output logic     miso_o,
    output logic     miso_oe_o,
    output logic     rx_o
);

    logic active;
    logic may_drive;

    always_comb begin
        active    = ctl_i.en && !fault_i;
        // Open-drain emulation: only a zero is ever actively driven.
        may_drive = !ctl_i.odm || !tx_i;
        mosi_o    = 1'b0;
        mosi_oe_o = 1'b0;
        miso_o    = 1'b0;
        miso_oe_o = 1'b0;
        if (ctl_i.mstr) begin
            mosi_o    = tx_i;
            mosi_oe_o = active && may_drive;
        end else begin
            miso_o    = tx_i;
            miso_oe_o = active && !ss_n_i && may_drive;
        end
        rx_o = ctl_i.mstr ? miso_i : mosi_i;
    end

endmodule

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl
    import spi_pad_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [CTL_BITS-1:0] reg_wdata,
    output logic [CTL_BITS-1:0] ctl_rdata,
    input  logic                eng_tx,
    output logic                eng_rx,
    output logic                eng_stop,
    output logic                mode_fault,
    input  logic                pad_ss_n_i,
    input  logic                pad_mosi_i,
    output logic                pad_mosi_o,
    output logic                pad_mosi_oe,
    input  logic                pad_miso_i,
    output logic                pad_miso_o,
    output logic                pad_miso_oe
);

    spi_ctl_t ctl;
    logic     ss_n_sync;
    logic     ctl_wr;
    logic     flt_clr;
    logic     fault;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_CTL);
    assign flt_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

    spi_pad_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (reg_wdata),
        .ctl_o   (ctl)
    );

    spi_pad_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_ss_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_ss_n_i),
        .q_o   (ss_n_sync)
    );

    spi_pad_fault i_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .ss_n_sync_i (ss_n_sync),
        .clr_i       (flt_clr),
        .fault_o     (fault)
    );

    spi_pad_drive i_drive (
        .ctl_i     (ctl),
        .fault_i   (fault),
        .tx_i      (eng_tx),
        .ss_n_i    (pad_ss_n_i),
        .mosi_i    (pad_mosi_i),
        .miso_i    (pad_miso_i),
        .mosi_o    (pad_mosi_o),
        .mosi_oe_o (pad_mosi_oe),
        .miso_o    (pad_miso_o),
        .miso_oe_o (pad_miso_oe),
        .rx_o      (eng_rx)
    );

    assign ctl_rdata  = ctl;
    assign mode_fault = fault;
    assign eng_stop   = fault;

endmodule

// File: rtl/spi_pad_ctrl_chk.sv
module spi_pad_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [3:0] reg_wdata,
    input logic [3:0] ctl_rdata,
    input logic       eng_tx,
    input logic       eng_stop,
    input logic       mode_fault,
    input logic       pad_mosi_oe,
    input logic       pad_miso_oe
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_mosi_oe && pad_miso_oe)); // R3

    AST_ODM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[3] && eng_tx) |-> (!pad_mosi_oe && !pad_miso_oe)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> (!pad_mosi_oe && !pad_miso_oe)); // R7

    AST_ROLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rdata[0]) |-> (ctl_rdata[1] == $past(ctl_rdata[1]))); // R8

    AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> $past(ctl_rdata[0] && ctl_rdata[1] && ctl_rdata[2])); // R9

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> (eng_stop && !pad_mosi_oe && !pad_miso_oe)); // R10

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !(reg_wr && reg_addr && reg_wdata[0])) |=> mode_fault); // R10

endmodule

bind spi_pad_ctrl spi_pad_ctrl_chk i_chk (.*);

// File: tb/test_spi_pad_ctrl.sv
module test_spi_pad_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] ctl_rdata;
    logic       eng_tx = 1'b0;
    logic       eng_rx, eng_stop, mode_fault;
    logic       pad_ss_n_i = 1'b1;
    logic       pad_mosi_i = 1'b0;
    logic       pad_mosi_o, pad_mosi_oe;
    logic       pad_miso_i = 1'b0;
    logic       pad_miso_o, pad_miso_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spi_pad_ctrl i_spi_pad_ctrl (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [3:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {mosi_oe, mosi_o, miso_oe, miso_o}
    function automatic logic [7:0] pads();
        return {4'b0, pad_mosi_oe, pad_mosi_o, pad_miso_oe, pad_miso_o};
    endfunction

    task automatic t_reset();
        check("R1 ctl", ctl_rdata, 0);
        check("R1 pads", pads(), 0);
        check("R1 fault/stop", {mode_fault, eng_stop}, 0);
    endtask

    task automatic t_fields();
        wr(0, 4'b1010);
        check("R2 readback", ctl_rdata, 8'hA);
        wr(0, 4'b0100);
        check("R2 readback psse", ctl_rdata, 8'h4);
        wr(0, 4'b0000);
    endtask

    task automatic t_master();
        wr(0, 4'b0010);
        wr(0, 4'b0011);
        eng_tx = 1'b0; #1;
        check("R3 tx0", pads(), 8'b1000);
        eng_tx = 1'b1; #1;
        check("R3 tx1", pads(), 8'b1100);
        pad_miso_i = 1'b1; pad_mosi_i = 1'b0; #1;
        check("R11 master rx", eng_rx, 1);
        wr(0, 4'b0010);
        check("R7 disabled master", pads(), 8'b0100);
        wr(0, 4'b1011);
        eng_tx = 1'b1; #1;
        check("R4 odm tx1", pads(), 8'b0100);
        eng_tx = 1'b0; #1;
        check("R4 odm tx0", pads(), 8'b1000);
    endtask

    task automatic t_slave();
        wr(0, 4'b0000);
        wr(0, 4'b0000);
        wr(0, 4'b0001);
        pad_ss_n_i = 1'b1; eng_tx = 1'b1; #1;
        check("R5 ss high", pads(), 8'b0001);
        pad_ss_n_i = 1'b0; #1;
        check("R5 ss low tx1", pads(), 8'b0011);
        eng_tx = 1'b0; #1;
        check("R5 ss low tx0", pads(), 8'b0010);
        pad_mosi_i = 1'b1; pad_miso_i = 1'b0; #1;
        check("R11 slave rx", eng_rx, 1);
        wr(0, 4'b1001);
        eng_tx = 1'b1; #1;
        check("R6 odm tx1", pads(), 8'b0001);
        eng_tx = 1'b0; #1;
        check("R6 odm tx0", pads(), 8'b0010);
        pad_ss_n_i = 1'b1; #1;
        check("R6 odm ss high", pads(), 8'b0000);
    endtask

    task automatic t_role_lock();
        wr(0, 4'b0011);
        check("R8 locked", ctl_rdata, 8'h1);
        wr(0, 4'b0010);
        check("R8 disable keeps role", ctl_rdata, 8'h0);
        wr(0, 4'b0010);
        check("R8 unlocked", ctl_rdata, 8'h2);
    endtask

    task automatic t_fault();
        pad_ss_n_i = 1'b1; eng_tx = 1'b0;
        wr(0, 4'b0111);
        idle(3);
        pad_ss_n_i = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R9 not yet", mode_fault, 0);
        @(posedge clk); #1;
        check("R9 third edge", mode_fault, 1);
        check("R10 pads quiet", pads(), 8'b0000);
        check("R10 stop", eng_stop, 1);
        @(negedge clk);
        pad_ss_n_i = 1'b1;
        idle(4);
        check("R10 sticky", mode_fault, 1);
        wr(1, 4'b0000);
        check("R10 write zero", mode_fault, 1);
        wr(1, 4'b0001);
        check("R10 cleared", {mode_fault, eng_stop}, 0);
        check("R10 pad back", pads(), 8'b1000);
    endtask

    task automatic t_no_fault();
        wr(0, 4'b0011);
        pad_ss_n_i = 1'b0;
        idle(6);
        check("R9 no protect", mode_fault, 0);
        pad_ss_n_i = 1'b1;
        wr(0, 4'b0110);
        pad_ss_n_i = 1'b0;
        idle(6);
        check("R7 disabled no fault", mode_fault, 0);
        check("R7 disabled pads", {pad_mosi_oe, pad_miso_oe}, 0);
        pad_ss_n_i = 1'b1;
        wr(0, 4'b0100);
        wr(0, 4'b0101);
        pad_ss_n_i = 1'b0;
        idle(6);
        check("R9 slave no fault", mode_fault, 0);
        check("R5 protected slave drives", pad_miso_oe, 1);
        pad_ss_n_i = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(2);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fields();
        t_master();
        t_slave();
        t_role_lock();
        t_fault();
        t_no_fault();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule